// File: doc/BRIEF.md
# I/O Chip Select Decoder with Wait States

This block sits beside an 8-bit CPU bus and produces four active-low chip selects for peripherals that live in the I/O address space. Each select has an 8-bit base register and an 8-bit control register. The control register holds an enable flag, an I/O-mode flag and a 3-bit wait count. When the CPU starts an I/O transfer, only the high byte of the 16-bit I/O address is compared with every base. The lowest-numbered select that qualifies wins. The block then drives the request and read/write strobes and holds the CPU with a ready signal for the number of clocks the winning select asks for.

A state machine with three named states runs each cycle. ST_IDLE waits for a transfer start. IDLE_TO_WAIT is taken on an I/O start whose winning select has a nonzero wait count. IDLE_TO_LAST is taken on an I/O start with a zero wait count or no winner. ST_WAIT counts down one clock at a time. It stays in place through WAIT_HOLD and leaves through WAIT_TO_LAST when the counter stands at one. ST_LAST is the final, ready clock of the transfer, and LAST_TO_IDLE closes it. The winner, its wait count and the transfer direction are captured when the cycle starts, so a configuration write during a transfer only affects later transfers. Addresses whose high byte is 00h belong to on-chip peripherals and never select an external device.

Top module: `io_cs_decoder`

## Requirements
- R1: After reset every control and base register is zero, all selects are disabled, cs_n is 4'b1111, iorq_n, rd_n and wr_n are 1 and ready is 1. An I/O transfer issued with this configuration asserts no chip select.
- R2: A start with bus_io=0 (memory transfer) asserts no chip select and no strobe, and leaves ready at 1.
- R3: Matching compares bus_addr[15:8] with the 8-bit base register. bus_addr[7:0], bus_addr[23:16] and bus_page have no effect on which select asserts.
- R4: Configuration writes go through cfg_we, cfg_sel (the select number) and cfg_base_sel (0 writes the control register, 1 writes the base register). A select qualifies only when its control bit 0 (enable) is 1, its control bit 1 (I/O mode) is 1 and its base matches.
- R5: When several selects qualify, only the lowest-numbered one asserts, so at most one cs_n bit is low at any time.
- R6: An address whose high byte is 00h (0000h to 00FFh) never asserts a chip select, even when a select's base is 00h and that select is enabled.
- R7: An I/O transfer drives iorq_n low from the clock after the start for wait+1 clocks. During the same clocks rd_n is low when bus_write=0 and wr_n is low when bus_write=1, and they are never low together. The winning cs_n bit is low for the same clocks.
- R8: ready is low for exactly the number of clocks held in control bits 7:5 of the winning select, starting at the clock after the start.
- R9: When no select qualifies, no wait clocks are inserted and the transfer completes in one clock.
- R10: A configuration write made during an active transfer does not change that transfer's select or wait count. It takes effect from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Select whose register is written |
| cfg_base_sel | input | 1 | 0: control register, 1: base register |
| cfg_wdata | input | 8 | Configuration write data |
| bus_start | input | 1 | One-clock pulse starting a bus transfer |
| bus_io | input | 1 | 1: I/O transfer, 0: memory transfer |
| bus_write | input | 1 | 1: write, 0: read |
| bus_addr | input | 24 | CPU address; only bits 15:8 are decoded |
| bus_page | input | 8 | Memory-mode page offset, ignored |
| cs_n | output | 4 | Active-low chip selects |
| iorq_n | output | 1 | Active-low I/O request |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ready | output | 1 | Low while wait clocks are inserted |

## Verification
All 256 high-byte values are swept twice, once under each of two configurations. The low byte, upper address byte and page are varied alongside the high byte, so a decode that looks at the wrong bits gives the wrong select. The first configuration has two selects sharing a base, which separates priority from match, and an enabled select with its I/O flag clear, which tests the qualify rule. The second configuration disables the former winner and gives a select the base 00h, which tests the peripheral window. The read/write direction alternates with the address, and the measured ready-low length is compared with each select's wait count, including 0 and 7. Separate checks cover a memory transfer, the reset state, and a reconfiguration written in the middle of a transfer.

// File: rtl/io_cs_pkg.sv
package io_cs_pkg;
    localparam int N_CS        = 4;
    localparam int REG_W       = 8;
    localparam int WAIT_W      = 3;
    localparam int WAIT_LSB    = 5;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_IO_BIT  = 1;
    localparam int ADDR_W      = 24;
    localparam int IO_W        = 16;
    localparam int PAGE_W      = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LAST = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/io_cs_cfg_regs.sv
module io_cs_cfg_regs
    import io_cs_pkg::*;
#(
    parameter int NSEL  = N_CS,
    parameter int RW    = REG_W,
    localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SEL_W-1:0]          sel,
    input  logic                      is_base,
    input  logic [RW-1:0]             wdata,
    output logic [NSEL-1:0][RW-1:0]   ctl,
    output logic [NSEL-1:0][RW-1:0]   base
);
    logic [NSEL-1:0][RW-1:0] ctl_q;
    logic [NSEL-1:0][RW-1:0] base_q;

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        logic hit;
        assign hit = we && (sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[g]  <= '0;
                base_q[g] <= '0;
            end else if (hit) begin
                if (is_base) begin
                    base_q[g] <= wdata;
                end else begin
                    ctl_q[g]  <= wdata;
                end
            end
        end
    end

    assign ctl  = ctl_q;
    assign base = base_q;
endmodule

// File: rtl/io_cs_match.sv
module io_cs_match
    import io_cs_pkg::*;
#(
    parameter int NSEL = N_CS,
    parameter int RW   = REG_W,
    parameter int WW   = WAIT_W
) (
    input  logic [NSEL-1:0][RW-1:0] ctl,
    input  logic [NSEL-1:0][RW-1:0] base,
    input  logic [RW-1:0]           hi_byte,
    output logic [NSEL-1:0]         win_oh,
    output logic [WW-1:0]           win_wait
);
    logic            in_window;
    logic [NSEL-1:0] qual;

    // High byte zero belongs to on-chip peripherals.
    assign in_window = (hi_byte == '0);

    for (genvar g = 0; g < NSEL; g++) begin : g_qual
        assign qual[g] = ctl[g][CTL_EN_BIT] && ctl[g][CTL_IO_BIT]
                         && (base[g] == hi_byte) && !in_window;
    end

    // Fixed priority: the lowest index wins.
    always_comb begin
        logic found;
        found    = 1'b0;
        win_oh   = '0;
        win_wait = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (qual[i] && !found) begin
                found     = 1'b1;
                win_oh[i] = 1'b1;
                win_wait  = ctl[i][WAIT_LSB +: WW];
            end
        end
    end
endmodule

// File: rtl/io_cs_wait_fsm.sv
module io_cs_wait_fsm
    import io_cs_pkg::*;
#(
    parameter int NSEL = N_CS,
    parameter int WW   = WAIT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_io,
    input  logic            is_write,
    input  logic [NSEL-1:0] win_oh,
    input  logic [WW-1:0]   win_wait,
    output logic [NSEL-1:0] cs_n,
    output logic            iorq_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic            ready
);
    cyc_state_t      state_q, state_d;
    logic [WW-1:0]   cnt_q;
    logic [NSEL-1:0] oh_q;
    logic            wr_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_io) begin
                    state_d = (win_wait != '0) ? ST_WAIT : ST_LAST;
                end
            end
            ST_WAIT: begin
                if (cnt_q == WW'(1)) begin
                    state_d = ST_LAST;
                end
            end
            ST_LAST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Per-cycle capture: winner, wait count and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            oh_q  <= '0;
            wr_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start_io) begin
            cnt_q <= win_wait;
            oh_q  <= win_oh;
            wr_q  <= is_write;
        end else if (state_q == ST_WAIT) begin
            cnt_q <= cnt_q - WW'(1);
        end
    end

    // Outputs.
    always_comb begin
        logic active;
        active = (state_q != ST_IDLE);
        cs_n   = active ? ~oh_q : '1;
        iorq_n = !active;
        rd_n   = !(active && !wr_q);
        wr_n   = !(active && wr_q);
        ready  = (state_q != ST_WAIT);
    end
endmodule

// File: rtl/io_cs_decoder.sv
module io_cs_decoder
    import io_cs_pkg::*;
#(
    parameter int NSEL  = N_CS,
    parameter int RW    = REG_W,
    parameter int WW    = WAIT_W,
    parameter int AW    = ADDR_W,
    parameter int PW    = PAGE_W,
    localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1,
    localparam int HI_LSB = IO_W - RW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_base_sel,
    input  logic [RW-1:0]    cfg_wdata,
    input  logic             bus_start,
    input  logic             bus_io,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [PW-1:0]    bus_page,
    output logic [NSEL-1:0]  cs_n,
    output logic             iorq_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             ready
);
    logic [NSEL-1:0][RW-1:0] ctl;
    logic [NSEL-1:0][RW-1:0] base;
    logic [NSEL-1:0]         win_oh;
    logic [WW-1:0]           win_wait;
    logic [RW-1:0]           hi_byte;
    logic                    unused_bits;

    assign hi_byte     = bus_addr[HI_LSB +: RW];
    assign unused_bits = ^{bus_addr[AW-1:IO_W], bus_addr[HI_LSB-1:0], bus_page};

    io_cs_cfg_regs #(.NSEL(NSEL), .RW(RW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .is_base (cfg_base_sel),
        .wdata   (cfg_wdata),
        .ctl     (ctl),
        .base    (base)
    );

    io_cs_match #(.NSEL(NSEL), .RW(RW), .WW(WW)) u_match (
        .ctl      (ctl),
        .base     (base),
        .hi_byte  (hi_byte),
        .win_oh   (win_oh),
        .win_wait (win_wait)
    );

    io_cs_wait_fsm #(.NSEL(NSEL), .WW(WW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_io (bus_start && bus_io),
        .is_write (bus_write),
        .win_oh   (win_oh),
        .win_wait (win_wait),
        .cs_n     (cs_n),
        .iorq_n   (iorq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ready    (ready)
    );
endmodule

// File: rtl/io_cs_checker.sv
module io_cs_checker
    import io_cs_pkg::*;
#(
    parameter int NSEL = N_CS,
    parameter int AW   = ADDR_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_start,
    input logic            bus_io,
    input logic [AW-1:0]   bus_addr,
    input logic [NSEL-1:0] cs_n,
    input logic            iorq_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ready
);
    assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_cs_in_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> !iorq_n);

    assert_rdwr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_dir_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !iorq_n |-> (rd_n != wr_n));

    assert_mem_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_io && iorq_n) |=> (iorq_n && cs_n == '1));

    assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_io && iorq_n && bus_addr[15:8] == 8'h00) |=> (cs_n == '1));

    assert_wait_in_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !iorq_n);

    assert_cs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && $past(!iorq_n) && $past(ready) == 1'b0) |-> $stable(cs_n));
endmodule

bind io_cs_decoder io_cs_checker #(.NSEL(NSEL), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .bus_io    (bus_io),
    .bus_addr  (bus_addr),
    .cs_n      (cs_n),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ready     (ready)
);

// File: tb/test_io_cs_decoder.sv
`timescale 1ns/1ps
module test_io_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic        cfg_base_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        bus_start = 1'b0;
    logic        bus_io = 1'b0;
    logic        bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_page = '0;
    logic [3:0]  cs_n;
    logic        iorq_n, rd_n, wr_n, ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ctl [4];
    logic [7:0] m_base[4];

    always #5 clk = ~clk;

    io_cs_decoder i_io_cs_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_base_sel(cfg_base_sel), .cfg_wdata(cfg_wdata),
        .bus_start(bus_start), .bus_io(bus_io), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_page(bus_page), .cs_n(cs_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_win(input logic [7:0] hb);
        if (hb == 8'h00) return -1;
        for (int i = 0; i < 4; i++)
            if (m_ctl[i][0] && m_ctl[i][1] && m_base[i] == hb) return i;
        return -1;
    endfunction

    task automatic cfg_write(input int sel, input bit is_base, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_base_sel = is_base; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (is_base) m_base[sel] = d; else m_ctl[sel] = d;
    endtask

    // One I/O transfer; optionally a control write to sel mid_sel during it.
    task automatic io_cycle(input logic [15:0] a, input bit wr, input logic [7:0] upper,
                            input logic [7:0] page, input bit mid, input int mid_sel,
                            input logic [7:0] mid_data);
        int ew, ei, w;
        logic [3:0] ecs, bad_cs;
        bit cs_bad, st_bad;
        ei  = exp_win(a[15:8]);
        ew  = (ei < 0) ? 0 : int'(m_ctl[ei][7:5]);
        ecs = (ei < 0) ? 4'hF : ~(4'b0001 << ei);
        bad_cs = ecs;
        @(negedge clk);
        bus_start = 1'b1; bus_io = 1'b1; bus_write = wr;
        bus_addr = {upper, a}; bus_page = page;
        @(negedge clk);
        bus_start = 1'b0;
        if (mid) begin
            cfg_we = 1'b1; cfg_sel = 2'(mid_sel); cfg_base_sel = 1'b0; cfg_wdata = mid_data;
            m_ctl[mid_sel] = mid_data;
        end
        w = 0; cs_bad = 0; st_bad = 0;
        for (int k = 0; k < 12; k++) begin
            if (cs_n !== ecs) begin cs_bad = 1; bad_cs = cs_n; end
            if (iorq_n !== 1'b0 || rd_n !== wr || wr_n !== !wr) st_bad = 1;
            if (ready === 1'b1) break;
            w++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        cfg_we = 1'b0;
        chk(!cs_bad, mid ? "R10" : "R3 R4 R5 R6", $sformatf("cs_n addr=%h", a),
            int'(bad_cs), int'(ecs));
        chk(w == ew, mid ? "R10" : (ei < 0 ? "R9" : "R8"),
            $sformatf("wait clocks addr=%h", a), w, ew);
        chk(!st_bad, "R7", $sformatf("strobes during transfer addr=%h wr=%0d", a, wr), 1, 0);
        @(negedge clk);
        chk(cs_n === 4'hF && iorq_n && rd_n && wr_n && ready, "R7",
            "idle after transfer", int'(cs_n), 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_ctl[i] = '0; m_base[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs_n === 4'hF, "R1", "cs_n after reset", int'(cs_n), 15);
        chk(iorq_n && rd_n && wr_n && ready, "R1", "strobes/ready after reset",
            int'({iorq_n, rd_n, wr_n, ready}), 15);
        io_cycle(16'h0000, 1'b0, 8'h00, 8'h00, 0, 0, 8'h0); // R1: all bases 0
        io_cycle(16'h1234, 1'b1, 8'hAA, 8'h55, 0, 0, 8'h0); // R1: nothing enabled

        // Configuration A: ctl = {wait[7:5], 000, io[1], en[0]}
        cfg_write(0, 1, 8'h40); cfg_write(0, 0, {3'd3, 5'b00011});
        cfg_write(1, 1, 8'h40); cfg_write(1, 0, {3'd5, 5'b00011}); // loses to cs0 (R5)
        cfg_write(2, 1, 8'h80); cfg_write(2, 0, {3'd7, 5'b00001}); // io flag clear (R4)
        cfg_write(3, 1, 8'h80); cfg_write(3, 0, {3'd2, 5'b00011});

        // R2: memory transfer to a matching address
        @(negedge clk);
        bus_start = 1'b1; bus_io = 1'b0; bus_addr = 24'h00_4000;
        @(negedge clk);
        bus_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(cs_n === 4'hF && iorq_n && rd_n && wr_n && ready, "R2",
                "memory transfer quiet", int'(cs_n), 15);
            @(negedge clk);
        end

        for (int hb = 0; hb < 256; hb++)
            io_cycle({8'(hb), 8'(hb) ^ 8'hC3}, 1'(hb), ~8'(hb), 8'(hb + 7), 0, 0, 8'h0);

        // R10: reprogram cs3 wait during its transfer
        io_cycle(16'h80FE, 1'b0, 8'h12, 8'h34, 1, 3, {3'd6, 5'b00011});
        io_cycle(16'h8001, 1'b1, 8'h00, 8'h00, 0, 0, 8'h0); // now 6 waits (R10)

        // Configuration B: cs0 off, cs1 at 40h with 0 waits, cs2 at 00h (R6)
        cfg_write(0, 0, 8'h00);
        cfg_write(1, 0, {3'd0, 5'b00011});
        cfg_write(2, 1, 8'h00); cfg_write(2, 0, {3'd4, 5'b00011});
        cfg_write(3, 1, 8'hFF); cfg_write(3, 0, {3'd7, 5'b00011});
        for (int hb = 0; hb < 256; hb++)
            io_cycle({8'(hb), 8'(hb) + 8'h5B}, !1'(hb), 8'(hb) ^ 8'h99, ~8'(hb), 0, 0, 8'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule